// File: doc/BRIEF.md
# Registered Instruction Decoder and Control Generator

This block takes one 32-bit instruction word per cycle and turns it into everything a simple load/store datapath needs to run it. It splits the word into source register numbers, a write-back register number, a 32-bit immediate and a 26-bit jump target. It also produces the control set: the ALU operation, the ALU second-operand select, register-write enable, memory read and write strobes, the write-back source, and the branch and jump flags. It uses three fixed word layouts. All of them share the 6-bit opcode in bits 31:26. An opcode of zero hands the choice over to the 6-bit function field in bits 5:0.

The decoded result is registered, so it appears one clock after the word is presented. A qualifying valid input travels with the word. When that input is low, the block suppresses all side-effecting strobes. Any encoding outside the supported subset raises an illegal flag instead of a control set. A write that would land on register 0 is dropped. Jump-and-link writes its return address into register 31.

Top module: `instr_decode_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero after that edge.
- R2: Outputs update one cycle after the input word. `out_valid` equals the previous cycle's `in_valid`. When `in_valid` was low, `reg_we`, `mem_rd`, `mem_wr`, `br_eq`, `br_ne`, `jmp`, `jmp_reg` and `illegal` are 0, and the other outputs still reflect the word.
- R3: `rs_idx` = word[25:21], `rt_idx` = word[20:16] and `jmp_tgt` = word[25:0], for every word.
- R4: `imm_ext` is word[15:0] zero-extended for opcodes 12 and 13, and is {word[15:0], 16'h0} for opcode 15. For every other word it is word[15:0] sign-extended.
- R5: Opcode 0 with funct 32, 34 or 42 gives `alu_op` 0, 1 or 2 respectively (add, subtract, set-less-than). It also gives `wr_idx` = word[15:11], register write, `alu_src_imm` = 0 and `wb_sel` = 0 (ALU).
- R6: Opcodes 8, 10, 12, 13 and 15 give `alu_op` 0, 2, 3, 4 and 5 respectively (add, set-less-than, AND, OR, pass operand B). They also give `wr_idx` = word[20:16], register write, `alu_src_imm` = 1 and `wb_sel` = 0.
- R7: Opcode 35 (load) gives `mem_rd`, `wb_sel` = 1 (memory), `wr_idx` = word[20:16], `alu_op` 0 and `alu_src_imm` = 1. Opcode 43 (store) gives `mem_wr`, `alu_op` 0 and `alu_src_imm` = 1, with no register write and `wr_idx` = 0.
- R8: Opcode 4 raises `br_eq` and opcode 5 raises `br_ne`. Both give `alu_op` 1, `alu_src_imm` = 0 and no register write.
- R9: Opcode 2 raises `jmp`. Opcode 3 raises `jmp` and writes register 31 with `wb_sel` = 2 (link). Opcode 0 with funct 8 raises `jmp_reg` with no register write.
- R10: When the selected write register is 0, `reg_we` is 0 and `wr_idx` is 0.
- R11: Any other opcode, or opcode 0 with any other funct, raises `illegal`. In that case `alu_op`, `wb_sel`, `alu_src_imm` and `wr_idx` are 0, and all strobes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result is valid |
| rs_idx | output | 5 | First source register |
| rt_idx | output | 5 | Second source register |
| wr_idx | output | 5 | Write-back register |
| imm_ext | output | 32 | Extended immediate |
| jmp_tgt | output | 26 | Jump target field |
| alu_op | output | 3 | ALU operation select |
| alu_src_imm | output | 1 | ALU operand B is the immediate |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link |
| reg_we | output | 1 | Register write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| br_eq | output | 1 | Branch if equal |
| br_ne | output | 1 | Branch if not equal |
| jmp | output | 1 | Direct jump |
| jmp_reg | output | 1 | Jump through register |
| illegal | output | 1 | Unsupported encoding |

## Verification
A directed set covers each supported encoding once. It includes negative and high-bit immediates, which separate sign from zero extension and the upper-half placement. It also includes a register-format write to register 0 and a load into register 0, which expose the write suppression. Unsupported opcodes and function codes next to supported ones show that `illegal` is exact and not a range test. A qualifying-low cycle and a reset asserted mid-stream show strobe gating and reset priority. A long pseudo-random run then mixes legal opcodes, legal and illegal function codes and fully random words, with random register fields. This catches any field that leaks between formats.

// File: rtl/idec_pkg.sv
// Package: shared encodings and control bundle for the instruction decoder.
// Assumes the fixed 32-bit word with opcode in [31:26] and funct in [5:0].
package idec_pkg;

    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int REG_W   = 5;

    // Opcode values.
    localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OP_W-1:0] OPC_J     = 6'd2;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

    // Function values under opcode zero.
    localparam logic [FN_W-1:0] FN_JR     = 6'd8;
    localparam logic [FN_W-1:0] FN_ADD    = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB    = 6'd34;
    localparam logic [FN_W-1:0] FN_SLT    = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_SLT  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_PASS = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_sel_e;

    typedef struct packed {
        alu_op_e   alu_op;
        wb_sel_e   wb_sel;
        ext_mode_e ext;
        dst_sel_e  dst;
        logic      alu_src_imm;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jmp;
        logic      jmp_reg;
        logic      illegal;
    } ctrl_t;

endpackage

// File: rtl/idec_fields.sv
// Module: splits an instruction word into its fixed-position fields.
// Assumes all three layouts share the opcode slot; pure wiring, no state.
module idec_fields #(
    parameter int INSTR_W = 32,
    parameter int REG_W   = 5,
    parameter int IMM_W   = 16,
    parameter int TGT_W   = 26
) (
    input  logic [INSTR_W-1:0] word,
    output logic [5:0]         op,
    output logic [5:0]         funct,
    output logic [REG_W-1:0]   rs,
    output logic [REG_W-1:0]   rt,
    output logic [REG_W-1:0]   rd,
    output logic [IMM_W-1:0]   imm,
    output logic [TGT_W-1:0]   tgt
);
    localparam int OP_LSB = INSTR_W - 6;
    localparam int RS_LSB = OP_LSB - REG_W;
    localparam int RT_LSB = RS_LSB - REG_W;
    localparam int RD_LSB = RT_LSB - REG_W;

    // Slice the word into fields at their fixed bit positions.
    always_comb begin
        op    = word[INSTR_W-1 -: 6];
        rs    = word[RS_LSB +: REG_W];
        rt    = word[RT_LSB +: REG_W];
        rd    = word[RD_LSB +: REG_W];
        funct = word[5:0];
        imm   = word[IMM_W-1:0];
        tgt   = word[TGT_W-1:0];
    end
endmodule

// File: rtl/idec_ctrl.sv
// Module: maps opcode and funct to the control bundle.
// Assumes unsupported encodings must yield an all-quiet bundle with illegal set.
module idec_ctrl
    import idec_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Decode the operation; default is the quiet illegal bundle.
    always_comb begin
        ctrl             = '0;
        ctrl.alu_op      = ALU_ADD;
        ctrl.wb_sel      = WB_ALU;
        ctrl.ext         = EXT_SIGN;
        ctrl.dst         = DST_NONE;
        ctrl.illegal     = 1'b1;
        unique case (op)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD: begin
                        ctrl.illegal = 1'b0;
                        ctrl.alu_op  = ALU_ADD;
                        ctrl.dst     = DST_RD;
                    end
                    FN_SUB: begin
                        ctrl.illegal = 1'b0;
                        ctrl.alu_op  = ALU_SUB;
                        ctrl.dst     = DST_RD;
                    end
                    FN_SLT: begin
                        ctrl.illegal = 1'b0;
                        ctrl.alu_op  = ALU_SLT;
                        ctrl.dst     = DST_RD;
                    end
                    FN_JR: begin
                        ctrl.illegal = 1'b0;
                        ctrl.jmp_reg = 1'b1;
                    end
                    default: ;
                endcase
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LUI: begin
                ctrl.illegal     = 1'b0;
                ctrl.alu_src_imm = 1'b1;
                ctrl.dst         = DST_RT;
                unique case (op)
                    OPC_ADDI: ctrl.alu_op = ALU_ADD;
                    OPC_SLTI: ctrl.alu_op = ALU_SLT;
                    OPC_ANDI: begin ctrl.alu_op = ALU_AND;  ctrl.ext = EXT_ZERO;  end
                    OPC_ORI:  begin ctrl.alu_op = ALU_OR;   ctrl.ext = EXT_ZERO;  end
                    default:  begin ctrl.alu_op = ALU_PASS; ctrl.ext = EXT_UPPER; end
                endcase
            end
            OPC_LW: begin
                ctrl.illegal     = 1'b0;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.wb_sel      = WB_MEM;
                ctrl.dst         = DST_RT;
            end
            OPC_SW: begin
                ctrl.illegal     = 1'b0;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_wr      = 1'b1;
            end
            OPC_BEQ, OPC_BNE: begin
                ctrl.illegal = 1'b0;
                ctrl.alu_op  = ALU_SUB;
                ctrl.br_eq   = (op == OPC_BEQ);
                ctrl.br_ne   = (op == OPC_BNE);
            end
            OPC_J: begin
                ctrl.illegal = 1'b0;
                ctrl.jmp     = 1'b1;
            end
            OPC_JAL: begin
                ctrl.illegal = 1'b0;
                ctrl.jmp     = 1'b1;
                ctrl.wb_sel  = WB_LINK;
                ctrl.dst     = DST_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idec_imm.sv
// Module: widens the 16-bit immediate by the mode the control picked.
// Assumes XLEN is at least twice IMM_W so the upper placement fits.
module idec_imm
    import idec_pkg::*;
#(
    parameter int IMM_W = 16,
    parameter int XLEN  = 32
) (
    input  logic [IMM_W-1:0] imm,
    input  ext_mode_e        mode,
    output logic [XLEN-1:0]  imm_ext
);
    localparam int PAD_W = XLEN - IMM_W;

    // Select sign, zero or upper-half placement.
    always_comb begin
        unique case (mode)
            EXT_ZERO:  imm_ext = {{PAD_W{1'b0}}, imm};
            EXT_UPPER: imm_ext = {imm, {PAD_W{1'b0}}};
            default:   imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
        endcase
    end
endmodule

// File: rtl/idec_dest.sv
// Module: chooses the write-back register and drops writes to register 0.
// Assumes the link register index is a fixed parameter.
module idec_dest
    import idec_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  dst_sel_e          dst,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rt,
    output logic [REG_W-1:0]  wr_idx,
    output logic              wr_en
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    logic [REG_W-1:0] pick;

    // Pick the raw destination index by selector.
    always_comb begin
        unique case (dst)
            DST_RD:   pick = rd;
            DST_RT:   pick = rt;
            DST_LINK: pick = LINK_IDX;
            default:  pick = '0;
        endcase
    end

    // Enable only for a nonzero destination.
    always_comb begin
        wr_en  = (pick != '0);
        wr_idx = pick;
    end
endmodule

// File: rtl/instr_decode_unit.sv
// Module: top of the decoder; registers one decoded word per cycle.
// Assumes synchronous active-low reset and that in_valid gates all strobes.
module instr_decode_unit
    import idec_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int REG_W    = 5,
    parameter int IMM_W    = 16,
    parameter int TGT_W    = 26,
    parameter int LINK_REG = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_word,
    output logic               out_valid,
    output logic [REG_W-1:0]   rs_idx,
    output logic [REG_W-1:0]   rt_idx,
    output logic [REG_W-1:0]   wr_idx,
    output logic [INSTR_W-1:0] imm_ext,
    output logic [TGT_W-1:0]   jmp_tgt,
    output logic [2:0]         alu_op,
    output logic               alu_src_imm,
    output logic [1:0]         wb_sel,
    output logic               reg_we,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               br_eq,
    output logic               br_ne,
    output logic               jmp,
    output logic               jmp_reg,
    output logic               illegal
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    logic [5:0]         f_op;
    logic [5:0]         f_fn;
    logic [REG_W-1:0]   f_rs;
    logic [REG_W-1:0]   f_rt;
    logic [REG_W-1:0]   f_rd;
    logic [IMM_W-1:0]   f_imm;
    logic [TGT_W-1:0]   f_tgt;
    ctrl_t              c;
    logic [INSTR_W-1:0] d_imm;
    logic [REG_W-1:0]   d_wr;
    logic               d_we;

    idec_fields #(
        .INSTR_W(INSTR_W), .REG_W(REG_W), .IMM_W(IMM_W), .TGT_W(TGT_W)
    ) u_fields (
        .word(in_word), .op(f_op), .funct(f_fn), .rs(f_rs), .rt(f_rt),
        .rd(f_rd), .imm(f_imm), .tgt(f_tgt)
    );

    idec_ctrl u_ctrl (
        .op(f_op), .funct(f_fn), .ctrl(c)
    );

    idec_imm #(
        .IMM_W(IMM_W), .XLEN(INSTR_W)
    ) u_imm (
        .imm(f_imm), .mode(c.ext), .imm_ext(d_imm)
    );

    idec_dest #(
        .REG_W(REG_W), .LINK_REG(LINK_REG)
    ) u_dest (
        .dst(c.dst), .rd(f_rd), .rt(f_rt), .wr_idx(d_wr), .wr_en(d_we)
    );

    // Register the decoded result; strobes are gated by in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            rs_idx      <= '0;
            rt_idx      <= '0;
            wr_idx      <= '0;
            imm_ext     <= '0;
            jmp_tgt     <= '0;
            alu_op      <= '0;
            alu_src_imm <= 1'b0;
            wb_sel      <= '0;
            reg_we      <= 1'b0;
            mem_rd      <= 1'b0;
            mem_wr      <= 1'b0;
            br_eq       <= 1'b0;
            br_ne       <= 1'b0;
            jmp         <= 1'b0;
            jmp_reg     <= 1'b0;
            illegal     <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            rs_idx      <= f_rs;
            rt_idx      <= f_rt;
            wr_idx      <= d_wr;
            imm_ext     <= d_imm;
            jmp_tgt     <= f_tgt;
            alu_op      <= c.alu_op;
            alu_src_imm <= c.alu_src_imm;
            wb_sel      <= c.wb_sel;
            reg_we      <= in_valid & d_we;
            mem_rd      <= in_valid & c.mem_rd;
            mem_wr      <= in_valid & c.mem_wr;
            br_eq       <= in_valid & c.br_eq;
            br_ne       <= in_valid & c.br_ne;
            jmp         <= in_valid & c.jmp;
            jmp_reg     <= in_valid & c.jmp_reg;
            illegal     <= in_valid & c.illegal;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(reg_we || mem_rd || mem_wr || br_eq || br_ne || jmp || jmp_reg || illegal)); // R2
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R7
    AST_LOAD_WB_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && wb_sel == 2'd1) |-> mem_rd); // R7
    AST_FLOW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_eq, br_ne, jmp, jmp_reg})); // R8
    AST_LINK_R31: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && wb_sel == 2'd2) |-> (wr_idx == LINK_IDX && jmp)); // R9
    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (wr_idx != '0)); // R10
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(reg_we || mem_rd || mem_wr || br_eq || br_ne || jmp || jmp_reg)); // R11
endmodule

// File: tb/instr_decode_unit_test.sv
module instr_decode_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic        out_valid;
    logic [4:0]  rs_idx, rt_idx, wr_idx;
    logic [31:0] imm_ext;
    logic [25:0] jmp_tgt;
    logic [2:0]  alu_op;
    logic        alu_src_imm;
    logic [1:0]  wb_sel;
    logic        reg_we, mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg, illegal;

    always #5 clk = ~clk;

    instr_decode_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .rs_idx(rs_idx), .rt_idx(rt_idx), .wr_idx(wr_idx),
        .imm_ext(imm_ext), .jmp_tgt(jmp_tgt), .alu_op(alu_op),
        .alu_src_imm(alu_src_imm), .wb_sel(wb_sel), .reg_we(reg_we),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .br_eq(br_eq), .br_ne(br_ne),
        .jmp(jmp), .jmp_reg(jmp_reg), .illegal(illegal)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected values for the word captured at the coming edge
    logic        e_valid;
    logic [4:0]  e_rs, e_rt, e_wr;
    logic [31:0] e_imm;
    logic [25:0] e_tgt;
    logic [2:0]  e_alu;
    logic        e_src;
    logic [1:0]  e_wb;
    logic        e_we, e_mrd, e_mwr, e_beq, e_bne, e_j, e_jr, e_ill;
    string       e_tag;

    task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
        end
    endtask

    // Behavioural reference: expected outputs for one word.
    task automatic model(input logic rst, input logic v, input logic [31:0] w);
        int op, fn, dest;
        op = w[31:26];
        fn = w[5:0];
        e_valid = 0; e_rs = 0; e_rt = 0; e_wr = 0; e_imm = 0; e_tgt = 0;
        e_alu = 0; e_src = 0; e_wb = 0; e_we = 0; e_mrd = 0; e_mwr = 0;
        e_beq = 0; e_bne = 0; e_j = 0; e_jr = 0; e_ill = 0; e_tag = "R1";
        if (!rst) return;
        e_valid = v;
        e_rs  = w[25:21];
        e_rt  = w[20:16];
        e_tgt = w[25:0];
        if (op == 12 || op == 13) e_imm = {16'h0, w[15:0]};               // R4
        else if (op == 15)        e_imm = {w[15:0], 16'h0};
        else                      e_imm = {{16{w[15]}}, w[15:0]};
        dest = -1;
        if (op == 0 && (fn == 32 || fn == 34 || fn == 42)) begin
            e_tag = "R5";
            e_alu = (fn == 32) ? 3'd0 : (fn == 34) ? 3'd1 : 3'd2;
            dest  = w[15:11];
        end else if (op == 0 && fn == 8) begin
            e_tag = "R9"; e_jr = 1;
        end else if (op == 8 || op == 10 || op == 12 || op == 13 || op == 15) begin
            e_tag = "R6"; e_src = 1; dest = w[20:16];
            case (op)
                8:  e_alu = 3'd0;
                10: e_alu = 3'd2;
                12: e_alu = 3'd3;
                13: e_alu = 3'd4;
                default: e_alu = 3'd5;
            endcase
        end else if (op == 35) begin
            e_tag = "R7"; e_src = 1; e_mrd = 1; e_wb = 2'd1; dest = w[20:16];
        end else if (op == 43) begin
            e_tag = "R7"; e_src = 1; e_mwr = 1;
        end else if (op == 4 || op == 5) begin
            e_tag = "R8"; e_alu = 3'd1; e_beq = (op == 4); e_bne = (op == 5);
        end else if (op == 2) begin
            e_tag = "R9"; e_j = 1;
        end else if (op == 3) begin
            e_tag = "R9"; e_j = 1; e_wb = 2'd2; dest = 31;
        end else begin
            e_tag = "R11"; e_ill = 1;
        end
        if (dest > 0) begin
            e_wr = dest[4:0]; e_we = 1;
        end else if (dest == 0) begin
            e_tag = "R10";
        end
        if (!v) begin
            e_tag = "R2";
            e_we = 0; e_mrd = 0; e_mwr = 0; e_beq = 0; e_bne = 0;
            e_j = 0; e_jr = 0; e_ill = 0;
        end
    endtask

    task automatic compare();
        chk("R2",  "out_valid", 32'(out_valid), 32'(e_valid));
        chk("R3",  "rs_idx",    32'(rs_idx),    32'(e_rs));
        chk("R3",  "rt_idx",    32'(rt_idx),    32'(e_rt));
        chk("R3",  "jmp_tgt",   32'(jmp_tgt),   32'(e_tgt));
        chk("R4",  "imm_ext",   imm_ext,        e_imm);
        chk(e_tag, "wr_idx",    32'(wr_idx),    32'(e_wr));
        chk(e_tag, "alu_op",    32'(alu_op),    32'(e_alu));
        chk(e_tag, "alu_src",   32'(alu_src_imm), 32'(e_src));
        chk(e_tag, "wb_sel",    32'(wb_sel),    32'(e_wb));
        chk(e_tag, "strobes",
            32'({reg_we, mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg, illegal}),
            32'({e_we, e_mrd, e_mwr, e_beq, e_bne, e_j, e_jr, e_ill}));
    endtask

    bit armed = 0;

    // One cycle: check the previous capture, then drive the next word.
    task automatic step(input logic rst, input logic v, input logic [31:0] w);
        @(negedge clk);
        if (armed) compare();
        rst_n    = rst;
        in_valid = v;
        in_word  = w;
        model(rst, v, w);
        armed = 1;
    endtask

    function automatic logic [31:0] rw(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] iw(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] jw(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    int legal_ops[14] = '{0, 0, 0, 2, 3, 4, 5, 8, 10, 12, 13, 15, 35, 43};
    int legal_fns[5]  = '{32, 34, 42, 8, 0};

    initial begin
        logic [31:0] s;
        logic [31:0] r, w;
        rst_n = 0; in_valid = 0; in_word = 0;
        // R1: reset with a busy input
        step(0, 1, iw(35, 3, 4, 16'h8000));
        step(0, 1, jw(3, 26'h3ffffff));
        step(1, 1, rw(17, 18, 8, 32));        // R5 add
        step(1, 1, rw(1, 2, 3, 34));          // R5 sub
        step(1, 1, rw(31, 30, 29, 42));       // R5 slt
        step(1, 1, rw(5, 6, 0, 32));          // R10 add to r0
        step(1, 1, iw(8, 29, 29, -4));        // R6 addi, R4 sign
        step(1, 1, iw(10, 8, 18, 10));        // R6 slti
        step(1, 1, iw(12, 29, 29, 16'h8006)); // R6 andi, R4 zero
        step(1, 1, iw(13, 2, 9, 16'hffff));   // R6 ori
        step(1, 1, iw(15, 7, 8, 16'haaaa));   // R6 lui, R4 upper
        step(1, 1, iw(35, 18, 9, 32));        // R7 lw
        step(1, 1, iw(35, 18, 0, 16'hfff0));  // R10 lw to r0
        step(1, 1, iw(43, 9, 8, 1200));       // R7 sw
        step(1, 1, iw(4, 19, 20, -3));        // R8 beq
        step(1, 1, iw(5, 8, 9, 25));          // R8 bne
        step(1, 1, jw(2, 2500));              // R9 j
        step(1, 1, jw(3, 26'h2aaaaaa));       // R9 jal
        step(1, 1, rw(31, 0, 0, 8));          // R9 jr
        step(1, 1, iw(1, 1, 1, 1));           // R11
        step(1, 1, iw(63, 31, 31, 16'hffff)); // R11
        step(1, 1, rw(1, 2, 3, 0));           // R11 funct 0
        step(1, 1, rw(1, 2, 3, 33));          // R11 funct 33
        step(1, 1, iw(9, 1, 2, 3));           // R11 op 9
        step(1, 0, iw(35, 4, 5, 6));          // R2 invalid load
        step(1, 0, jw(3, 5));                 // R2 invalid jal
        step(1, 1, iw(43, 1, 2, 3));
        step(0, 1, iw(43, 1, 2, 3));          // R1 mid-run reset
        step(1, 1, iw(43, 1, 2, 3));
        // pseudo-random sweep
        s = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            r = s;
            if (r[2:0] == 3'd0) begin
                w = {r[31:3], 3'b101};
            end else begin
                w = {6'(legal_ops[r[7:4] % 14]), r[31:6], 6'd0};
                w[25:0] = {r[31:6]};
                if (w[31:26] == 6'd0) w[5:0] = 6'(legal_fns[r[10:8] % 5]);
                if (r[12:11] == 2'd0 && w[31:26] == 6'd0) w[15:11] = 5'd0;
            end
            step(1, (r[15:13] != 3'd0), w);
        end
        step(1, 0, 32'h0);
        step(1, 0, 32'h0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule